// File: doc/BRIEF.md
# 8-bit Timer with Compare and Prescaler

An 8-bit up-counter whose clock comes from a 10-bit prescaler. A 3-bit clock select picks one of seven divisors from the prescaler, or stops the counter. In free-running mode the count climbs to 0xFF, rolls over to 0x00 and raises an overflow flag. In auto-reload mode a match against the compare register sends the count back to zero. That gives a period of compare+1 ticks.

The count is compared with an 8-bit compare register on every tick, and equality raises a match flag. Each flag drives its own interrupt request through its own mask bit. Software clears a flag by writing a one to its bit, or the interrupt logic clears it with a per-source acknowledge strobe. All registers sit behind a simple single-cycle write port with a combinational read port.

Top module: `timer8`

## Requirements
- R1: After reset the control, count, compare, mask and flag registers read 0, and both interrupt requests are low.
- R2: Register map on the 3-bit address:
  - 0 is control: bits [2:0] select the clock, bit 3 selects auto-reload.
  - 1 is the count, and 2 is compare.
  - 3 is the mask: bit 1 enables the match interrupt, bit 0 the overflow interrupt.
  - 4 is the flags: bit 1 is match, bit 0 is overflow.
  - Unused bits and addresses read 0.
- R3: Clock select 0 stops the counter and holds the prescaler at zero. Values 1 to 7 divide by 1, 8, 32, 64, 128, 256 and 1024. Leaving the stopped state with divisor N, the count first advances on the Nth clock edge after the control write.
- R4: In free-running mode (control bit 3 = 0) each tick increments the count. A tick at 0xFF gives 0x00 and sets the overflow flag.
- R5: A tick on which the count equals the compare value sets the match flag. This holds in both modes.
- R6: In auto-reload mode (control bit 3 = 1) a matching tick loads 0 instead of incrementing.
- R7: Each interrupt request is high exactly when its flag is set and its mask bit is 1.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R9: A high acknowledge strobe (overflow or match) clears its own flag on the next edge.
- R10: A write to the count loads it and takes precedence over a tick in the same cycle. A write on a tick edge suppresses that tick's flag events. No match is taken on the first tick after the write.
- R11: If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| ack_cmp | input | 1 | Match interrupt acknowledge |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Match interrupt request |

## Verification
The assertions check on every cycle that:
- the overflow flag rises only after a count of 0xFF;
- the match flag rises only after count equalled compare;
- a request is never high with its mask clear;
- a stopped counter holds its value;
- a count write loads the written value;
- an auto-reload match returns the count to zero;
- strobes and write-one clears remove a flag when no tick competes.

Only the bench scenarios can show the divisor periods measured from a stopped start, the single suppressed match after a count write, and set-over-clear on the wrap edge. A cycle model in the bench compares the readback of every register and both requests during a long random run.

// File: rtl/timer8.sv
module timer8 #(
  parameter int DW  = 8,
  parameter int PSW = 10,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ack_ovf,
  input  logic          ack_cmp,
  output logic          irq_ovf,
  output logic          irq_cmp
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_CMP  = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_FLAG = AW'(4);
  localparam logic [DW-1:0] CNT_TOP = '1;

  logic [2:0]     sel;
  logic           ctc;
  logic [DW-1:0]  cnt, ocr;
  logic [1:0]     msk;
  logic           f_ovf, f_cmp, blk;
  logic [PSW-1:0] pre;
  logic           tick, match, wrap;

  function automatic logic [PSW-1:0] tap_mask(input logic [2:0] s);
    case (s)
      3'd2:    return PSW'(7);
      3'd3:    return PSW'(31);
      3'd4:    return PSW'(63);
      3'd5:    return PSW'(127);
      3'd6:    return PSW'(255);
      3'd7:    return PSW'(1023);
      default: return '0;
    endcase
  endfunction

  wire wr_ctrl = bus_we && (bus_addr == A_CTRL);
  wire wr_cnt  = bus_we && (bus_addr == A_CNT);
  wire wr_cmp  = bus_we && (bus_addr == A_CMP);
  wire wr_mask = bus_we && (bus_addr == A_MASK);
  wire wr_flag = bus_we && (bus_addr == A_FLAG);

  assign tick  = (sel != 3'd0) && ((pre & tap_mask(sel)) == tap_mask(sel));
  assign match = tick && !blk && !wr_cnt && (cnt == ocr);
  assign wrap  = tick && !wr_cnt && !(ctc && match) && (cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)          pre <= '0;
    else if (sel == 3'd0) pre <= '0;
    else                 pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (wr_cnt) begin
      cnt <= bus_wdata;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= (ctc && match) ? '0 : cnt + 1'b1;
      blk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      ctc <= 1'b0;
      ocr <= '0;
      msk <= '0;
    end else begin
      if (wr_ctrl) begin
        sel <= bus_wdata[2:0];
        ctc <= bus_wdata[3];
      end
      if (wr_cmp)  ocr <= bus_wdata;
      if (wr_mask) msk <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_ovf <= 1'b0;
      f_cmp <= 1'b0;
    end else begin
      f_ovf <= wrap  | (f_ovf & ~(ack_ovf | (wr_flag & bus_wdata[0])));
      f_cmp <= match | (f_cmp & ~(ack_cmp | (wr_flag & bus_wdata[1])));
    end
  end

  assign irq_ovf = f_ovf & msk[0];
  assign irq_cmp = f_cmp & msk[1];

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(DW-4){1'b0}}, ctc, sel};
      A_CNT:   bus_rdata = cnt;
      A_CMP:   bus_rdata = ocr;
      A_MASK:  bus_rdata = {{(DW-2){1'b0}}, msk};
      A_FLAG:  bus_rdata = {{(DW-2){1'b0}}, f_cmp, f_ovf};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/timer8_chk.sv
module timer8_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          ack_ovf,
  input logic          ack_cmp,
  input logic          irq_ovf,
  input logic          irq_cmp,
  input logic [2:0]    sel,
  input logic          ctc,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] ocr,
  input logic [1:0]    msk,
  input logic          f_ovf,
  input logic          f_cmp,
  input logic          blk,
  input logic          tick
);
  wire cnt_wr  = bus_we && (bus_addr == AW'(1));
  wire flag_wr = bus_we && (bus_addr == AW'(4));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr) |=> (cnt == $past(cnt)));

  p_ovf_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ovf) |-> ($past(cnt) == {DW{1'b1}}));

  p_cmp_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_cmp) |-> ($past(cnt) == $past(ocr)));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc && tick && !blk && !cnt_wr && cnt == ocr) |=> (cnt == '0 && f_cmp));

  p_ovf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> msk[0]);

  p_cmp_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp |-> msk[1]);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && bus_wdata[0] && !tick) |=> !f_ovf);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cmp && !tick) |=> !f_cmp);

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(bus_wdata) && blk));
endmodule

bind timer8 timer8_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
  .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .sel(sel), .ctc(ctc),
  .cnt(cnt), .ocr(ocr), .msk(msk), .f_ovf(f_ovf), .f_cmp(f_cmp),
  .blk(blk), .tick(tick)
);

// File: tb/test_timer8.sv
`timescale 1ns/1ps
module test_timer8;
  logic       clk = 1'b0, rst_n = 1'b0, we = 1'b0, ao = 1'b0, ac = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_o, irq_c;
  int n_cmp = 0, n_bad = 0;

  timer8 i_timer8 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ack_ovf(ao), .ack_cmp(ac),
    .irq_ovf(irq_o), .irq_cmp(irq_c)
  );

  always #2.5 clk = ~clk;

  logic [2:0] m_sel;
  logic       m_ctc, m_fo, m_fc, m_blk;
  logic [7:0] m_cnt, m_ocr;
  logic [1:0] m_msk;
  logic [9:0] m_pre;
  logic       t_tick, t_match, t_wrap, t_wcnt, t_nfo, t_nfc;

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 32;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 256;
      default: return 1024;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = '0; m_ctc = 0; m_fo = 0; m_fc = 0; m_blk = 0;
      m_cnt = '0; m_ocr = '0; m_msk = '0; m_pre = '0;
    end else begin
      t_wcnt  = we && addr == 3'd1;
      t_tick  = (m_sel != 0) && ((int'(m_pre) % divisor(m_sel)) == divisor(m_sel) - 1);
      t_match = t_tick && !m_blk && !t_wcnt && (m_cnt == m_ocr);
      t_wrap  = t_tick && !t_wcnt && !(m_ctc && t_match) && (m_cnt == 8'hFF);
      t_nfo = t_wrap  || (m_fo && !(ao || (we && addr == 3'd4 && wdata[0])));
      t_nfc = t_match || (m_fc && !(ac || (we && addr == 3'd4 && wdata[1])));
      m_pre = (m_sel == 0) ? 10'd0 : m_pre + 10'd1;
      if (t_wcnt) begin m_cnt = wdata; m_blk = 1; end
      else if (t_tick) begin m_cnt = (m_ctc && t_match) ? 8'd0 : m_cnt + 8'd1; m_blk = 0; end
      if (we && addr == 3'd0) begin m_sel = wdata[2:0]; m_ctc = wdata[3]; end
      if (we && addr == 3'd2) m_ocr = wdata;
      if (we && addr == 3'd3) m_msk = wdata[1:0];
      m_fo = t_nfo; m_fc = t_nfc;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, m_ctc, m_sel};
      3'd1: return m_cnt;
      3'd2: return m_ocr;
      3'd3: return {6'b0, m_msk};
      3'd4: return {6'b0, m_fc, m_fo};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic o, input logic c);
    we = w; addr = a; wdata = d; ao = o; ac = c;
    @(posedge clk);
    @(negedge clk);
    we = 0; ao = 0; ac = 0;
    chk("R2 model readback", rdata, exp_rd(addr));
    chk("R7 model irq", {6'b0, irq_c, irq_o}, {6'b0, m_fc & m_msk[1], m_fo & m_msk[0]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, addr, 8'h00, 0, 0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    we = 0; addr = a;
    #0.1;
    v = rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1717));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1 reset register", v, 8'h00); end
    chk("R1 reset irq", {6'b0, irq_c, irq_o}, 8'h00);

    // R4 wrap and overflow flag, R10 load
    step(1, 3'd2, 8'h80, 0, 0);
    step(1, 3'd3, 8'h03, 0, 0);
    step(1, 3'd0, 8'h01, 0, 0);
    step(1, 3'd1, 8'hFE, 0, 0);
    rd(3'd1, v); chk("R10 count load", v, 8'hFE);
    idle(1); rd(3'd1, v); chk("R4 count up", v, 8'hFF);
    idle(1); rd(3'd1, v); chk("R4 wrap to zero", v, 8'h00);
    rd(3'd4, v); chk("R4 overflow flag", v, 8'h01);
    chk("R7 overflow irq", {7'b0, irq_o}, 8'h01);

    // R8 write-one-to-clear
    step(1, 3'd4, 8'h02, 0, 0); rd(3'd4, v); chk("R8 zero bit keeps flag", v, 8'h01);
    step(1, 3'd4, 8'h01, 0, 0); rd(3'd4, v); chk("R8 one bit clears flag", v, 8'h00);

    // R5 match, R9 acknowledge
    step(1, 3'd1, 8'h7E, 0, 0);
    idle(2); rd(3'd4, v); chk("R5 no flag before match", v, 8'h00);
    idle(1); rd(3'd4, v); chk("R5 match flag", v, 8'h02);
    chk("R7 match irq", {7'b0, irq_c}, 8'h01);
    step(0, 3'd4, 8'h00, 0, 1); rd(3'd4, v); chk("R9 ack clears match", v, 8'h00);

    // R7 masked request
    step(1, 3'd3, 8'h01, 0, 0);
    step(1, 3'd1, 8'h7F, 0, 0);
    idle(2); rd(3'd4, v); chk("R7 flag set while masked", v, 8'h02);
    chk("R7 masked irq low", {7'b0, irq_c}, 8'h00);
    step(1, 3'd4, 8'h02, 0, 0);
    step(1, 3'd3, 8'h03, 0, 0);

    // R10 match blocked on first tick after count write
    step(1, 3'd1, 8'h80, 0, 0);
    idle(1); rd(3'd1, v); chk("R10 count after blocked tick", v, 8'h81);
    rd(3'd4, v); chk("R10 match suppressed", v, 8'h00);

    // R6 auto-reload
    step(1, 3'd2, 8'h05, 0, 0);
    step(1, 3'd0, 8'h09, 0, 0);
    step(1, 3'd1, 8'h03, 0, 0);
    idle(2); rd(3'd1, v); chk("R6 reach compare", v, 8'h05);
    idle(1); rd(3'd1, v); chk("R6 reload to zero", v, 8'h00);
    rd(3'd4, v); chk("R6 match flag on reload", v, 8'h02);
    idle(1); rd(3'd1, v); chk("R6 count after reload", v, 8'h01);
    step(1, 3'd4, 8'h03, 0, 0);

    // R3 stop and divisors
    step(1, 3'd0, 8'h00, 0, 0);
    rd(3'd1, v);
    begin
      logic [7:0] held;
      held = v;
      idle(20); rd(3'd1, v); chk("R3 stopped count holds", v, held);
    end
    step(1, 3'd1, 8'h00, 0, 0);
    step(1, 3'd0, 8'h02, 0, 0);
    idle(7); rd(3'd1, v); chk("R3 div8 before period", v, 8'h00);
    idle(1); rd(3'd1, v); chk("R3 div8 first tick", v, 8'h01);
    step(1, 3'd0, 8'h00, 0, 0);
    step(1, 3'd0, 8'h07, 0, 0);
    idle(1023); rd(3'd1, v); chk("R3 div1024 before period", v, 8'h01);
    idle(1); rd(3'd1, v); chk("R3 div1024 first tick", v, 8'h02);

    // R11 set beats clear
    step(1, 3'd0, 8'h01, 0, 0);
    step(1, 3'd2, 8'h80, 0, 0);
    step(1, 3'd4, 8'h03, 0, 0);
    step(1, 3'd1, 8'hFE, 0, 0);
    idle(1);
    step(1, 3'd4, 8'h01, 0, 0); rd(3'd4, v); chk("R11 wrap beats write clear", v, 8'h01);
    step(1, 3'd4, 8'h03, 0, 0);
    step(1, 3'd1, 8'hFE, 0, 0);
    idle(1);
    step(0, 3'd4, 8'h00, 1, 0); rd(3'd4, v); chk("R11 wrap beats ack", v, 8'h01);

    // random run checked against the cycle model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] a;
      logic [7:0] d;
      r = int'($urandom % 16);
      a = 3'($urandom % 6);
      d = 8'($urandom);
      if (r < 9) step(0, a, 8'h00, ($urandom % 8) == 0, ($urandom % 8) == 0);
      else begin
        if (a == 3'd0)
          d = {4'b0, 1'($urandom % 2), (($urandom % 4) == 0) ? 3'($urandom % 8)
                                       : ((($urandom % 2) == 1) ? 3'd1 : 3'd2)};
        if (a == 3'd1 && ($urandom % 3) == 0) d = 8'hFC + 8'($urandom % 4);
        if (a == 3'd2 && ($urandom % 2) == 0) d = 8'($urandom % 16);
        step(1, a, d, 0, 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule